// File: doc/BRIEF.md
# Result-latency interlock scoreboard

This block sits at the issue stage of a single-issue, in-order pipeline. Each cycle it sees one decoded instruction: its class, an optional destination register and up to three optional source registers. It keeps one countdown per architectural register, giving the number of cycles left until a pending result can be forwarded. It raises `stall` when any enabled source is not yet ready, or when the execute stage is still held by an earlier multi-cycle instruction.

An instruction issues when `in_valid` is high and `stall` is low. When it issues, the destination's countdown is loaded from a latency table indexed by class, replacing any older pending value. Register 15 is the program counter and is never tracked. A store's data operand, carried in source slot 2, may take a single-word load result one cycle early. The store's address operands, in slots 0 and 1, cannot.

Conditional instructions are taken to always execute. Decoding, forwarding muxes and the register file lie outside the block.

Top module: `rl_interlock`

## Requirements
- R1: Class 0 (plain ALU, with or without a constant shift) has latency 1: an instruction reading its destination issues in the very next cycle without a stall. Class codes 8 to 15 behave as class 0.
- R2: Class 1 (ALU with a register-specified shift) has latency 2. It holds execute for one extra cycle, so any valid instruction in the cycle right after it stalls.
- R3: Class 2 (word or byte load) and class 3 (doubleword load) have latency 2. Class 4 (three- or four-word load) has latency 3 and holds execute for two extra cycles.
- R4: When a class 5 store reads, through slot 2 (bits 11:8 of `in_src`), a register whose pending producer is a class 2 load, the operand is ready one cycle after the load issues. Slots 0 and 1 (bits 3:0 and 7:4), non-store consumers, and class 3 or 4 producers get no early path.
- R5: Class 5 (store) and class 6 (branch) have latency 0: a destination they name is readable in the next cycle.
- R6: Class 7 (call) has latency 32: a reader of its destination stalls for 31 cycles after issue and issues in the 32nd.
- R7: An issuing instruction's destination countdown replaces whatever was pending for that register, whether that value was longer or shorter.
- R8: Register 15 is never tracked: reading it never causes a stall, whatever wrote it.
- R9: `stall` is high only when `in_valid` is high and either an enabled source is not ready or execute is held. Sources whose enable bit is low, and cycles with `in_valid` low, never stall.
- R10: An instruction that is stalled or not valid leaves no trace: it loads no countdown and does not hold execute.
- R11: After synchronous reset, every register is ready and execute is free, whatever was pending before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 4 | Instruction class code (see R1 to R6) |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst | input | 4 | Destination register index |
| in_src_en | input | 3 | Per-slot source enables, bit k for slot k |
| in_src | input | 12 | Source indices, slot k at bits 4k+3:4k |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
A countdown that is loaded wrongly, or that decays at the wrong rate, appears at the ports as a stall that ends a cycle early or late. It shows only when a consumer of that register is presented, and within the latency window of the class that wrote it. A lost or stale early-path flag shows as the single cycle right after a load. A held-execute count that is off shows as an extra or missing stall on the cycle after a class 1 or class 4 issue, even for unrelated instructions. State left behind by a stalled instruction appears only later, as a false stall on its destination or on the next instruction.

// File: rtl/rl_pkg.sv
package rl_pkg;

  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU       = 4'd0,
    CL_ALU_SHREG = 4'd1,
    CL_LD_WORD   = 4'd2,
    CL_LD_DUAL   = 4'd3,
    CL_LD_MULTI  = 4'd4,
    CL_STORE     = 4'd5,
    CL_BRANCH    = 4'd6,
    CL_CALL      = 4'd7
  } op_class_e;

endpackage

// File: rtl/rl_lat_table.sv
module rl_lat_table
  import rl_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned OCC_W      = 2,
  parameter int unsigned LAT_ALU    = 1,
  parameter int unsigned LAT_SHREG  = 2,
  parameter int unsigned LAT_LDW    = 2,
  parameter int unsigned LAT_LDD    = 2,
  parameter int unsigned LAT_LDM    = 3,
  parameter int unsigned LAT_STORE  = 0,
  parameter int unsigned LAT_BRANCH = 0,
  parameter int unsigned LAT_CALL   = 32,
  parameter int unsigned OCC_SHREG  = 1,
  parameter int unsigned OCC_LDM    = 2
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             early_o,
  output logic [OCC_W-1:0] occ_o
);

  // The counter holds latency minus one, so ready means zero.
  function automatic logic [CNT_W-1:0] to_cnt(input int unsigned lat);
    if (lat == 0) return '0;
    return CNT_W'(lat - 1);
  endfunction

  localparam logic [CNT_W-1:0] C_ALU    = to_cnt(LAT_ALU);
  localparam logic [CNT_W-1:0] C_SHREG  = to_cnt(LAT_SHREG);
  localparam logic [CNT_W-1:0] C_LDW    = to_cnt(LAT_LDW);
  localparam logic [CNT_W-1:0] C_LDD    = to_cnt(LAT_LDD);
  localparam logic [CNT_W-1:0] C_LDM    = to_cnt(LAT_LDM);
  localparam logic [CNT_W-1:0] C_STORE  = to_cnt(LAT_STORE);
  localparam logic [CNT_W-1:0] C_BRANCH = to_cnt(LAT_BRANCH);
  localparam logic [CNT_W-1:0] C_CALL   = to_cnt(LAT_CALL);

  always_comb begin
    cnt_o   = C_ALU;
    early_o = 1'b0;
    occ_o   = '0;
    case (cls_i)
      CL_ALU_SHREG: begin
        cnt_o = C_SHREG;
        occ_o = OCC_W'(OCC_SHREG);
      end
      CL_LD_WORD: begin
        cnt_o   = C_LDW;
        early_o = 1'b1;
      end
      CL_LD_DUAL:  cnt_o = C_LDD;
      CL_LD_MULTI: begin
        cnt_o = C_LDM;
        occ_o = OCC_W'(OCC_LDM);
      end
      CL_STORE:  cnt_o = C_STORE;
      CL_BRANCH: cnt_o = C_BRANCH;
      CL_CALL:   cnt_o = C_CALL;
      default:   cnt_o = C_ALU;
    endcase
  end

endmodule

// File: rtl/rl_reg_bank.sv
module rl_reg_bank #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned PC_IDX = 15,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [CNT_W-1:0]           wr_cnt,
  input  logic                       wr_early,
  output logic [NREG-1:0][CNT_W-1:0] cnt_o,
  output logic [NREG-1:0]            early_o
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == PC_IDX) begin : g_pc
      assign cnt_o[r]   = '0;
      assign early_o[r] = 1'b0;
    end else begin : g_trk
      logic [CNT_W-1:0] cnt_q;
      logic             early_q;
      logic             hit;

      assign hit = wr_en && (wr_idx == IDX_W'(r));

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q   <= '0;
          early_q <= 1'b0;
        end else if (hit) begin
          cnt_q   <= wr_cnt;
          early_q <= wr_early;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign cnt_o[r]   = cnt_q;
      assign early_o[r] = early_q;

      AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt_o[r] == $past(wr_cnt)));  // R7
      AST_CNT_DECAY: assert property (@(posedge clk) disable iff (rst)
        (!hit && cnt_o[r] != '0) |=> (cnt_o[r] == $past(cnt_o[r]) - 1'b1));  // R1
    end
  end

endmodule

// File: rtl/rl_src_check.sv
module rl_src_check #(
  parameter int unsigned NREG      = 16,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned NSRC      = 3,
  parameter int unsigned DATA_SLOT = 2,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic [NSRC-1:0]             src_en,
  input  logic [NSRC-1:0][IDX_W-1:0]  src_idx,
  input  logic                        is_store,
  input  logic [NREG-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NREG-1:0]             early_i,
  output logic                        hazard_o
);

  logic [NSRC-1:0] blocked;

  for (genvar k = 0; k < NSRC; k++) begin : g_slot
    logic [CNT_W-1:0] c;
    logic             early_ok;

    assign c = cnt_i[src_idx[k]];

    if (k == DATA_SLOT) begin : g_data
      assign early_ok = is_store && early_i[src_idx[k]] && (c == CNT_W'(1));
    end else begin : g_addr
      assign early_ok = 1'b0;
    end

    assign blocked[k] = src_en[k] && (c != '0) && !early_ok;
  end

  assign hazard_o = |blocked;

endmodule

// File: rtl/rl_exec_occ.sv
module rl_exec_occ #(
  parameter int unsigned OCC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [OCC_W-1:0] extra_i,
  output logic             busy_o
);

  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else if (issue_i) begin
      occ_q <= extra_i;
    end else if (occ_q != '0) begin
      occ_q <= occ_q - 1'b1;
    end
  end

  assign busy_o = (occ_q != '0);

  AST_OCC_SET: assert property (@(posedge clk) disable iff (rst)
    (issue_i && extra_i != '0) |=> busy_o);  // R2
  AST_OCC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (occ_q == OCC_W'(1) && !issue_i) |=> !busy_o);  // R3

endmodule

// File: rtl/rl_interlock.sv
module rl_interlock
  import rl_pkg::*;
#(
  parameter int unsigned NREG      = 16,
  parameter int unsigned NSRC      = 3,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned OCC_W     = 2,
  parameter int unsigned PC_IDX    = 15,
  parameter int unsigned DATA_SLOT = 2,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [CLS_W-1:0]      in_class,
  input  logic                  in_dst_en,
  input  logic [IDX_W-1:0]      in_dst,
  input  logic [NSRC-1:0]       in_src_en,
  input  logic [NSRC*IDX_W-1:0] in_src,
  output logic                  stall
);

  logic [NSRC-1:0][IDX_W-1:0]  src_v;
  logic [CNT_W-1:0]            lat_cnt;
  logic                        lat_early;
  logic [OCC_W-1:0]            lat_occ;
  logic [NREG-1:0][CNT_W-1:0]  cnt;
  logic [NREG-1:0]             early;
  logic                        hazard;
  logic                        occ_busy;
  logic                        issue;
  logic                        bank_wr;
  logic                        is_store;

  assign src_v    = in_src;
  assign is_store = (in_class == CL_STORE);

  rl_lat_table #(
    .CNT_W (CNT_W),
    .OCC_W (OCC_W)
  ) u_lat (
    .cls_i   (in_class),
    .cnt_o   (lat_cnt),
    .early_o (lat_early),
    .occ_o   (lat_occ)
  );

  rl_reg_bank #(
    .NREG   (NREG),
    .CNT_W  (CNT_W),
    .PC_IDX (PC_IDX)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bank_wr),
    .wr_idx   (in_dst),
    .wr_cnt   (lat_cnt),
    .wr_early (lat_early),
    .cnt_o    (cnt),
    .early_o  (early)
  );

  rl_src_check #(
    .NREG      (NREG),
    .CNT_W     (CNT_W),
    .NSRC      (NSRC),
    .DATA_SLOT (DATA_SLOT)
  ) u_chk (
    .src_en   (in_src_en),
    .src_idx  (src_v),
    .is_store (is_store),
    .cnt_i    (cnt),
    .early_i  (early),
    .hazard_o (hazard)
  );

  rl_exec_occ #(
    .OCC_W (OCC_W)
  ) u_occ (
    .clk     (clk),
    .rst     (rst),
    .issue_i (issue),
    .extra_i (lat_occ),
    .busy_o  (occ_busy)
  );

  assign stall   = in_valid && (hazard || occ_busy);
  assign issue   = in_valid && !stall;
  assign bank_wr = issue && in_dst_en && (in_dst != IDX_W'(PC_IDX));

  // Every enabled source names the program counter.
  logic pc_only;
  always_comb begin
    pc_only = 1'b1;
    for (int k = 0; k < NSRC; k++) begin
      if (in_src_en[k] && (src_v[k] != IDX_W'(PC_IDX))) pc_only = 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !stall);  // R9
  AST_PC_NEVER_WAITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !occ_busy && pc_only) |-> !stall);  // R8
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |-> !bank_wr);  // R10

endmodule

// File: tb/test_rl_interlock.sv
`timescale 1ns/1ps
module test_rl_interlock;

  localparam logic [3:0] C_ALU  = 4'd0;
  localparam logic [3:0] C_SHR  = 4'd1;
  localparam logic [3:0] C_LDW  = 4'd2;
  localparam logic [3:0] C_LDD  = 4'd3;
  localparam logic [3:0] C_LDM  = 4'd4;
  localparam logic [3:0] C_ST   = 4'd5;
  localparam logic [3:0] C_BR   = 4'd6;
  localparam logic [3:0] C_CALL = 4'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_class = '0;
  logic        in_dst_en = 1'b0;
  logic [3:0]  in_dst = '0;
  logic [2:0]  in_src_en = '0;
  logic [11:0] in_src = '0;
  logic        stall;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit          exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rl_interlock i_rl_interlock (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_dst_en (in_dst_en),
    .in_dst    (in_dst),
    .in_src_en (in_src_en),
    .in_src    (in_src),
    .stall     (stall)
  );

  task automatic drv(input logic v, input logic [3:0] cls, input logic de,
                     input logic [3:0] d, input logic [2:0] se,
                     input logic [3:0] s0, input logic [3:0] s1,
                     input logic [3:0] s2, input bit exp, input string tag);
    @(negedge clk);
    in_valid  = v;
    in_class  = cls;
    in_dst_en = de;
    in_dst    = d;
    in_src_en = se;
    in_src    = {s2, s1, s0};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: compare the stall of each presented cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (stall !== e) begin
          failures++;
          $display("FAIL %s: stall actual=%0b expected=%0b", t, stall, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state, then reset clears a pending call
    drv(0, C_ALU, 0, 0, 3'b000, 0, 0, 0, 0, "R11 idle after reset");
    drv(1, C_ALU, 0, 0, 3'b001, 1, 0, 0, 0, "R11 fresh r1 ready");
    drv(1, C_CALL, 1, 1, 3'b000, 0, 0, 0, 0, "R11 call issues");
    do_reset(2);
    drv(1, C_ALU, 0, 0, 3'b001, 1, 0, 0, 0, "R11 r1 ready after reset");

    // R1
    drv(1, C_ALU, 1, 1, 3'b000, 0, 0, 0, 0, "R1 producer");
    drv(1, C_ALU, 1, 2, 3'b001, 1, 0, 0, 0, "R1 consumer next cycle");
    drv(1, 4'd9, 1, 3, 3'b000, 0, 0, 0, 0, "R1 class9 producer");
    drv(1, C_ALU, 0, 0, 3'b001, 3, 0, 0, 0, "R1 class9 consumer");

    // R2
    drv(1, C_SHR, 1, 2, 3'b000, 0, 0, 0, 0, "R2 shreg issue");
    drv(1, C_ALU, 0, 0, 3'b001, 3, 0, 0, 1, "R2 execute held");
    drv(1, C_ALU, 0, 0, 3'b001, 2, 0, 0, 0, "R2 result at two");

    // R3 word load
    drv(1, C_LDW, 1, 4, 3'b000, 0, 0, 0, 0, "R3 ldw issue");
    drv(1, C_ALU, 0, 0, 3'b001, 4, 0, 0, 1, "R3 ldw not ready");
    drv(1, C_ALU, 0, 0, 3'b001, 4, 0, 0, 0, "R3 ldw ready");

    // R4 early store data
    drv(1, C_LDW, 1, 5, 3'b000, 0, 0, 0, 0, "R4 load");
    drv(1, C_ST, 0, 0, 3'b101, 6, 0, 5, 0, "R4 store data early");
    drv(1, C_LDW, 1, 5, 3'b000, 0, 0, 0, 0, "R4 load");
    drv(1, C_ST, 0, 0, 3'b001, 5, 0, 0, 1, "R4 slot0 address no early");
    drv(1, C_ST, 0, 0, 3'b001, 5, 0, 0, 0, "R4 slot0 address at two");
    drv(1, C_LDW, 1, 5, 3'b000, 0, 0, 0, 0, "R4 load");
    drv(1, C_ST, 0, 0, 3'b010, 0, 5, 0, 1, "R4 slot1 address no early");
    drv(1, C_ST, 0, 0, 3'b010, 0, 5, 0, 0, "R4 slot1 address at two");
    drv(1, C_LDW, 1, 5, 3'b000, 0, 0, 0, 0, "R4 load");
    drv(1, C_ALU, 0, 0, 3'b100, 0, 0, 5, 1, "R4 non-store slot2");
    drv(1, C_ALU, 0, 0, 3'b100, 0, 0, 5, 0, "R4 non-store slot2 at two");

    // R3 doubleword, R4 no early path from it
    drv(1, C_LDD, 1, 7, 3'b000, 0, 0, 0, 0, "R3 ldd issue");
    drv(1, C_ST, 0, 0, 3'b100, 0, 0, 7, 1, "R4 dual load no early");
    drv(1, C_ST, 0, 0, 3'b100, 0, 0, 7, 0, "R3 ldd ready at two");

    // R3 multi-word load
    drv(1, C_LDM, 1, 8, 3'b000, 0, 0, 0, 0, "R3 ldm issue");
    drv(1, C_ALU, 0, 0, 3'b001, 9, 0, 0, 1, "R3 ldm execute held 1");
    drv(1, C_ALU, 0, 0, 3'b001, 9, 0, 0, 1, "R3 ldm execute held 2");
    drv(1, C_ALU, 0, 0, 3'b001, 8, 0, 0, 0, "R3 ldm ready at three");

    // R5
    drv(1, C_BR, 1, 12, 3'b000, 0, 0, 0, 0, "R5 branch issue");
    drv(1, C_ALU, 0, 0, 3'b001, 12, 0, 0, 0, "R5 branch zero latency");
    drv(1, C_ST, 1, 13, 3'b000, 0, 0, 0, 0, "R5 store issue");
    drv(1, C_ALU, 0, 0, 3'b001, 13, 0, 0, 0, "R5 store zero latency");

    // R6
    drv(1, C_CALL, 1, 14, 3'b000, 0, 0, 0, 0, "R6 call issue");
    for (int k = 1; k <= 31; k++)
      drv(1, C_ALU, 0, 0, 3'b001, 14, 0, 0, 1, "R6 call pending");
    drv(1, C_ALU, 0, 0, 3'b001, 14, 0, 0, 0, "R6 call done at 32");

    // R7
    drv(1, C_CALL, 1, 11, 3'b000, 0, 0, 0, 0, "R7 call issue");
    drv(1, C_ALU, 1, 11, 3'b000, 0, 0, 0, 0, "R7 overwrite issues");
    drv(1, C_ALU, 0, 0, 3'b001, 11, 0, 0, 0, "R7 shorter newest wins");
    drv(1, C_ALU, 1, 10, 3'b000, 0, 0, 0, 0, "R7 alu issue");
    drv(1, C_CALL, 1, 10, 3'b000, 0, 0, 0, 0, "R7 call overwrite issues");
    drv(1, C_ALU, 0, 0, 3'b001, 10, 0, 0, 1, "R7 longer newest wins");

    // R8
    drv(1, C_LDW, 1, 15, 3'b000, 0, 0, 0, 0, "R8 load to pc");
    drv(1, C_ALU, 0, 0, 3'b111, 15, 15, 15, 0, "R8 pc untracked after load");
    drv(1, C_CALL, 1, 15, 3'b000, 0, 0, 0, 0, "R8 call to pc");
    drv(1, C_ALU, 0, 0, 3'b001, 15, 0, 0, 0, "R8 pc untracked after call");

    // R9
    drv(1, C_LDW, 1, 4, 3'b000, 0, 0, 0, 0, "R9 load");
    drv(1, C_ALU, 0, 0, 3'b000, 4, 4, 4, 0, "R9 disabled sources");
    drv(1, C_LDW, 1, 4, 3'b000, 0, 0, 0, 0, "R9 load");
    drv(0, C_ALU, 0, 0, 3'b111, 4, 4, 4, 0, "R9 invalid never stalls");

    // R10
    drv(1, C_LDW, 1, 1, 3'b000, 0, 0, 0, 0, "R10 load");
    drv(1, C_CALL, 1, 3, 3'b001, 1, 0, 0, 1, "R10 stalled call");
    drv(1, C_ALU, 0, 0, 3'b001, 3, 0, 0, 0, "R10 stalled call left no countdown");
    drv(0, C_CALL, 1, 6, 3'b000, 0, 0, 0, 0, "R10 invalid call");
    drv(1, C_ALU, 0, 0, 3'b001, 6, 0, 0, 0, "R10 invalid call left no countdown");
    drv(1, C_LDW, 1, 1, 3'b000, 0, 0, 0, 0, "R10 load");
    drv(1, C_LDM, 1, 2, 3'b001, 1, 0, 0, 1, "R10 stalled multi load");
    drv(1, C_ALU, 0, 0, 3'b000, 0, 0, 0, 0, "R10 stalled multi left execute free");
    drv(1, C_ALU, 0, 0, 3'b001, 2, 0, 0, 0, "R10 stalled multi left no countdown");

    drv(0, C_ALU, 0, 0, 3'b000, 0, 0, 0, 0, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end

endmodule